// File: doc/BRIEF.md
# Compressed Program-Counter Trace Packer

This block records a stream of executed program-counter values into a circular trace memory. It saves space by writing the full 18-bit address only when execution leaves the current 64-address block. While execution stays inside that block, it packs up to three 6-bit in-block offsets into one line. Each 20-bit line has a 2-bit information code in its top bits. The code tells a reader whether the line holds a full address or one, two or three offsets.

Software or a debug sequencer starts a session with an arm pulse and ends it with a stop pulse. While the block is armed, every cycle with a valid PC adds one entry. The write pointer, the saturating count of valid lines and the rollover flag are available as registered outputs. A second, independent port reads any line of the memory with one cycle of latency. The RAM is split into lanes with separate write enables. Because of this, an offset line rewritten after a wrap keeps its older upper fields. Only the information code says how far the new data reaches.

Top module: `pc_trace_packer`

## Requirements
- R1: Synchronous reset clears `armed_o`, `wr_ptr_o`, `line_count_o` and `rollover_o` to 0. An `arm_i` pulse with `stop_i` low has the same effect, except that it sets `armed_o` to 1. No PC is captured in the cycle of the arm pulse.
- R2: The first line written after arming holds the full PC in bits 17:0, with information code 00 in bits 19:18.
- R3: When PC[17:6] differs from the stored base block, a full line (code 00, PC in bits 17:0) is written and that block becomes the new base.
- R4: A PC in the base block that does not join an open offset line starts a new line. That line has code 01 and PC[5:0] in bits 5:0. A line is open when fewer than three offsets have been written to it.
- R5: The second and third offsets of an open line go to bits 11:6 and bits 17:12 of the same line, and set its code to 10 and 11. The fourth offset starts a new line.
- R6: `wr_ptr_o` advances by one, modulo 64, only when a new line is started. `line_count_o` counts the lines started and saturates at 64.
- R7: When the pointer wraps from 63 to 0, `rollover_o` is set and stays set until the next arm. The next entry after a wrap is always a full line, even if its PC lies in the base block.
- R8: An offset line written over an older line after a wrap changes only the fields it fills and the code. The older contents of its upper fields remain.
- R9: With `armed_o` low, or with `pc_valid_i` low, the pointer, the count and the memory stay unchanged.
- R10: A `stop_i` pulse clears `armed_o` in the next cycle. It takes priority over `arm_i`, and no PC is captured in that cycle.
- R11: `rd_data_o` presents the line at `rd_addr_i` one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Start a new capture session |
| stop_i | input | 1 | End the capture session |
| pc_valid_i | input | 1 | `pc_i` holds an executed PC this cycle |
| pc_i | input | 18 | Executed program counter |
| rd_addr_i | input | 6 | Read line address |
| rd_data_o | output | 20 | Line at the read address (code in 19:18) |
| armed_o | output | 1 | Capture session active |
| wr_ptr_o | output | 6 | Next line to be started |
| line_count_o | output | 7 | Valid lines, saturating at 64 |
| rollover_o | output | 1 | Pointer has wrapped this session |

## Verification
The assertions check these rules on every cycle:
- the count never exceeds the depth and the pointer moves only by single steps or back to zero on arm (R6);
- a stop or arm takes effect on the next cycle (R1, R10);
- the pointer is frozen while disarmed (R9);
- the rollover flag is set on a wrap and then holds (R7);
- every memory write fills either a single field or all three (R5).

The exact packing of lines can only be shown by the bench's scenarios, which read lines back and compare their contents:
- which field receives each offset and which code it carries (R2 to R5);
- the forced full line after a wrap (R7);
- the survival of older upper fields in a refilled line (R8).

// File: rtl/pct_pkg.sv
package pct_pkg;
  localparam int INFO_W = 2;
  localparam logic [INFO_W-1:0] INFO_BASE  = 2'b00;
  localparam logic [INFO_W-1:0] INFO_ONE   = 2'b01;
  localparam logic [INFO_W-1:0] INFO_TWO   = 2'b10;
  localparam logic [INFO_W-1:0] INFO_THREE = 2'b11;
endpackage

// File: rtl/pct_lane_mem.sv
module pct_lane_mem #(
  parameter int W     = 6,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pct_session.sv
module pct_session #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm_i,
  input  logic          stop_i,
  input  logic          start_line,
  output logic          armed,
  output logic [AW-1:0] wr_ptr,
  output logic [CW-1:0] count,
  output logic          rollover,
  output logic          wrap
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  assign wrap = start_line && (wr_ptr == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      wr_ptr   <= '0;
      count    <= '0;
      rollover <= 1'b0;
    end else if (stop_i) begin
      armed <= 1'b0;
    end else if (arm_i) begin
      armed    <= 1'b1;
      wr_ptr   <= '0;
      count    <= '0;
      rollover <= 1'b0;
    end else if (start_line) begin
      wr_ptr <= wrap ? '0 : wr_ptr + 1'b1;
      if (count != FULL) count <= count + 1'b1;
      if (wrap) rollover <= 1'b1;
    end
  end
endmodule

// File: rtl/pct_packer.sv
module pct_packer
  import pct_pkg::*;
#(
  parameter int PC_W  = 18,
  parameter int OFS_W = 6,
  parameter int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int SLOTS = PC_W / OFS_W,
  localparam int BLK_W = PC_W - OFS_W,
  localparam int FW    = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              take,
  input  logic [PC_W-1:0]   pc,
  input  logic [AW-1:0]     wr_ptr,
  input  logic              wrap,
  output logic [SLOTS-1:0]  field_we,
  output logic              info_we,
  output logic [AW-1:0]     waddr,
  output logic [PC_W-1:0]   wdata,
  output logic [INFO_W-1:0] info,
  output logic              start_line
);
  logic [BLK_W-1:0] base_q;
  logic             need_base_q;
  logic [FW-1:0]    fill_q;
  logic [AW-1:0]    cur_q;
  logic             new_blk;
  logic             new_ofs_line;

  assign new_blk      = need_base_q || (pc[PC_W-1:OFS_W] != base_q);
  assign new_ofs_line = (fill_q == '0) || (fill_q == FW'(SLOTS));

  always_comb begin
    field_we   = '0;
    info       = INFO_BASE;
    waddr      = wr_ptr;
    wdata      = {SLOTS{pc[OFS_W-1:0]}};
    start_line = 1'b0;
    if (take) begin
      if (new_blk) begin
        field_we   = '1;
        wdata      = pc;
        start_line = 1'b1;
      end else if (new_ofs_line) begin
        field_we[0] = 1'b1;
        info        = INFO_ONE;
        start_line  = 1'b1;
      end else begin
        waddr = cur_q;
        info  = INFO_W'(fill_q) + 1'b1;
        for (int k = 0; k < SLOTS; k++)
          if (fill_q == FW'(k)) field_we[k] = 1'b1;
      end
    end
  end

  assign info_we = |field_we;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      base_q      <= '0;
      need_base_q <= 1'b1;
      fill_q      <= '0;
      cur_q       <= '0;
    end else if (take) begin
      if (new_blk) begin
        base_q      <= pc[PC_W-1:OFS_W];
        need_base_q <= wrap;
        fill_q      <= '0;
        cur_q       <= wr_ptr;
      end else if (new_ofs_line) begin
        need_base_q <= wrap;
        fill_q      <= FW'(1);
        cur_q       <= wr_ptr;
      end else begin
        fill_q <= fill_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pc_trace_packer.sv
module pc_trace_packer
  import pct_pkg::*;
#(
  parameter int PC_W  = 18,
  parameter int OFS_W = 6,
  parameter int DEPTH = 64,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int SLOTS  = PC_W / OFS_W,
  localparam int LINE_W = PC_W + INFO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm_i,
  input  logic              stop_i,
  input  logic              pc_valid_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [LINE_W-1:0] rd_data_o,
  output logic              armed_o,
  output logic [AW-1:0]     wr_ptr_o,
  output logic [CW-1:0]     line_count_o,
  output logic              rollover_o
);
  logic              take;
  logic              restart;
  logic              wrap;
  logic              start_line;
  logic [SLOTS-1:0]  field_we;
  logic              info_we;
  logic [AW-1:0]     waddr;
  logic [PC_W-1:0]   wdata;
  logic [INFO_W-1:0] info;

  assign restart = arm_i && !stop_i;
  assign take    = pc_valid_i && armed_o && !arm_i && !stop_i;

  pct_session #(.DEPTH(DEPTH)) u_session (
    .clk(clk), .rst(rst), .arm_i(arm_i), .stop_i(stop_i),
    .start_line(start_line), .armed(armed_o), .wr_ptr(wr_ptr_o),
    .count(line_count_o), .rollover(rollover_o), .wrap(wrap)
  );

  pct_packer #(.PC_W(PC_W), .OFS_W(OFS_W), .DEPTH(DEPTH)) u_packer (
    .clk(clk), .rst(rst), .restart(restart), .take(take), .pc(pc_i),
    .wr_ptr(wr_ptr_o), .wrap(wrap), .field_we(field_we), .info_we(info_we),
    .waddr(waddr), .wdata(wdata), .info(info), .start_line(start_line)
  );

  for (genvar g = 0; g < SLOTS; g++) begin : g_field
    pct_lane_mem #(.W(OFS_W), .DEPTH(DEPTH)) u_mem (
      .clk(clk), .we(field_we[g]), .waddr(waddr),
      .wdata(wdata[g*OFS_W +: OFS_W]), .raddr(rd_addr_i),
      .rdata(rd_data_o[g*OFS_W +: OFS_W])
    );
  end

  pct_lane_mem #(.W(INFO_W), .DEPTH(DEPTH)) u_info_mem (
    .clk(clk), .we(info_we), .waddr(waddr), .wdata(info),
    .raddr(rd_addr_i), .rdata(rd_data_o[LINE_W-1:PC_W])
  );
endmodule

// File: rtl/pct_checker.sv
module pct_checker #(
  parameter int DEPTH = 64,
  parameter int SLOTS = 3,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             arm_i,
  input logic             stop_i,
  input logic             armed_o,
  input logic [AW-1:0]    wr_ptr_o,
  input logic [CW-1:0]    line_count_o,
  input logic             rollover_o,
  input logic             start_line,
  input logic [SLOTS-1:0] field_we
);
  assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
    line_count_o <= CW'(DEPTH));

  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr_o != $past(wr_ptr_o)) |->
      (wr_ptr_o == '0 || wr_ptr_o == $past(wr_ptr_o) + 1'b1));

  assert_arm_clears_R1: assert property (@(posedge clk) disable iff (rst)
    (arm_i && !stop_i) |=> (armed_o && line_count_o == '0 && !rollover_o && wr_ptr_o == '0));

  assert_stop_disarms_R10: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> !armed_o);

  assert_idle_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (!armed_o && !arm_i) |=> $stable(wr_ptr_o) && $stable(line_count_o));

  assert_wrap_sets_R7: assert property (@(posedge clk) disable iff (rst)
    (start_line && wr_ptr_o == AW'(DEPTH - 1) && !arm_i && !stop_i) |=> rollover_o);

  assert_rollover_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (rollover_o && !arm_i) |=> rollover_o);

  assert_field_write_shape_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(field_we) || (&field_we));
endmodule

bind pc_trace_packer pct_checker #(.DEPTH(DEPTH), .SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst(rst), .arm_i(arm_i), .stop_i(stop_i), .armed_o(armed_o),
  .wr_ptr_o(wr_ptr_o), .line_count_o(line_count_o), .rollover_o(rollover_o),
  .start_line(start_line), .field_we(field_we)
);

// File: tb/pc_trace_packer_tb.sv
module pc_trace_packer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  localparam int NL = 7;

  localparam logic [17:0] V_PC [NV] = '{18'h01234, 18'h01235, 18'h01236, 18'h0123A,
    18'h0123B, 18'h20000, 18'h20001, 18'h01200, 18'h01201, 18'h01202};
  localparam int V_PTR [NV] = '{1, 2, 2, 2, 3, 4, 5, 6, 7, 7};
  localparam logic [19:0] V_LINE [NL] = '{20'h01234, 20'hFADB5, 20'h4003B,
    20'h20000, 20'h40001, 20'h01200, 20'h80081};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        arm_i = 1'b0;
  logic        stop_i = 1'b0;
  logic        pc_valid_i = 1'b0;
  logic [17:0] pc_i = '0;
  logic [5:0]  rd_addr_i = '0;
  logic [19:0] rd_data_o;
  logic        armed_o;
  logic [5:0]  wr_ptr_o;
  logic [6:0]  line_count_o;
  logic        rollover_o;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_trace_packer u_dut (
    .clk(clk), .rst(rst), .arm_i(arm_i), .stop_i(stop_i),
    .pc_valid_i(pc_valid_i), .pc_i(pc_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .armed_o(armed_o), .wr_ptr_o(wr_ptr_o),
    .line_count_o(line_count_o), .rollover_o(rollover_o)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [17:0] pc);
    @(negedge clk);
    pc_valid_i = 1'b1;
    pc_i = pc;
    @(negedge clk);
    pc_valid_i = 1'b0;
  endtask

  task automatic arm();
    @(negedge clk);
    arm_i = 1'b1;
    @(negedge clk);
    arm_i = 1'b0;
  endtask

  task automatic read_line(input int addr, output logic [19:0] line);
    @(negedge clk);
    rd_addr_i = 6'(addr);
    @(negedge clk);
    line = rd_data_o;
  endtask

  // Keep only the fields the code says are filled
  function automatic logic [19:0] masked(input logic [19:0] line);
    case (line[19:18])
      2'b01:   return {line[19:18], 12'h0, line[5:0]};
      2'b10:   return {line[19:18], 6'h0, line[11:0]};
      default: return line;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [19:0] line;
    int p;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 reset armed", armed_o, 0);
    check("R1 reset ptr", wr_ptr_o, 0);
    check("R1 reset count", line_count_o, 0);
    check("R1 reset rollover", rollover_o, 0);

    // R9 PC ignored while disarmed
    push(18'h00111);
    check("R9 disarmed ptr", wr_ptr_o, 0);

    arm();
    check("R1 arm armed", armed_o, 1);
    check("R1 arm ptr", wr_ptr_o, 0);

    // Table walk: R2, R3, R4, R5, R6
    for (int i = 0; i < NV; i++) begin
      push(V_PC[i]);
      check("R6 ptr after vector", wr_ptr_o, V_PTR[i]);
    end
    check("R6 count", line_count_o, NL);
    // R9: idle cycles with pc_valid low
    repeat (4) @(negedge clk);
    check("R9 idle ptr", wr_ptr_o, NL);
    for (int i = 0; i < NL; i++) begin
      read_line(i, line);
      // R2 line 0, R3 lines 3 and 5, R4 R5 lines 1,2,4,6, R11 read port
      check("R2 R3 R4 R5 R11 line", masked(line), V_LINE[i]);
    end

    // R10 stop, then PCs ignored
    @(negedge clk);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    check("R10 stop armed", armed_o, 0);
    push(18'h3FFFF);
    check("R9 after stop ptr", wr_ptr_o, NL);
    read_line(NL, line);
    read_line(0, line);
    check("R9 line 0 untouched", masked(line), V_LINE[0]);

    // Wrap scenario: R6, R7, R8
    arm();
    check("R1 rearm count", line_count_o, 0);
    push(18'h00000);
    push(18'h00001);
    push(18'h00002);
    push(18'h00003);
    for (int i = 1; i <= 62; i++) push(18'(i << 6));
    check("R7 wrapped ptr", wr_ptr_o, 0);
    check("R7 rollover set", rollover_o, 1);
    check("R6 count full", line_count_o, 64);
    push(18'h00F85);
    push(18'h00F86);
    check("R6 ptr after wrap", wr_ptr_o, 2);
    check("R6 count saturated", line_count_o, 64);
    check("R7 rollover held", rollover_o, 1);
    read_line(0, line);
    check("R7 forced full line", line, 20'h00F85);
    read_line(1, line);
    check("R8 refilled line keeps old fields", line, 20'h43086);
    read_line(63, line);
    check("R3 last line", line, 20'h00F80);

    arm();
    check("R1 rearm clears rollover", rollover_o, 0);
    p = wr_ptr_o;
    check("R1 rearm ptr", p, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule